// File: doc/BRIEF.md
# Trigger Timing and Resync Controller

This block sits between the command decoder of a detector module controller and the front-end chips. It takes single-cycle trigger, front-end resync and full resync pulses that have already been decoded. It drives the trigger line and the resync line of the front-end chips. Each accepted trigger can become a burst of consecutive trigger pulses. The burst is delayed by a programmable number of clock cycles before it reaches the chips.

The block counts the triggers still awaiting readout. It refuses a new trigger once that count reaches a programmable cap, and it lowers the count on each event-done pulse. Every accepted trigger is numbered by an 8-bit counter, and that number is pushed toward a pending-trigger FIFO outside the block. When the pending count falls to zero, the block sends one front-end resync by itself, unless a configuration bit disables this.

Top module: `trig_sync_ctrl`

## Requirements
- R1: After reset, `fe_trig_out`, `fe_sync_out` and `pend_push` are low, and `pend_cnt`, `trig_count` and `pend_num` are zero.
- R2: `trig_in` is accepted only when all three of these hold in the same cycle: no sync command is present, `pend_cnt` is below the cap, and no burst is in progress. A burst is in progress from the cycle after an acceptance for N cycles. The cap is `cfg_max_pend`, and 0 counts as 1. A refused trigger changes no output and no count.
- R3: An accepted trigger produces exactly N consecutive high cycles on `fe_trig_out`. N is `cfg_burst_len`, and 0 counts as 1.
- R4: The first pulse of a burst appears D+1 cycles after the cycle in which `trig_in` was accepted, where D is `cfg_delay` (0 to 15).
- R5: `pend_cnt` rises by one for each accepted trigger and falls by one for each `event_done`. It is unchanged when both occur in the same cycle. It never goes below 0 or above 15. The new value is visible in the cycle after the event.
- R6: In the cycle after an acceptance, `pend_push` is high for one cycle and `pend_num` holds the value `trig_count` had when the trigger was accepted. `trig_count` then rises by one, modulo 256.
- R7: `sync_fe_cmd` makes `fe_sync_out` high in the next cycle. It clears `pend_cnt`, any burst in progress and the delay line, and it drops a trigger that arrives in the same cycle. It leaves `trig_count` unchanged.
- R8: `sync_all_cmd` does everything `sync_fe_cmd` does and also clears `trig_count` to 0.
- R9: When `event_done` takes `pend_cnt` from 1 to 0, `fe_sync_out` goes high for one cycle, two cycles after that `event_done`. It fires once per entry into the idle state. When `cfg_auto_sync_dis` is 1, it does not fire. Clearing the count with a sync command never adds an automatic pulse.
- R10: Each resync is a single-cycle pulse on `fe_sync_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one period per 25 ns slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Decoded trigger pulse, at least 3 cycles apart |
| sync_fe_cmd | input | 1 | Front-end resync command pulse |
| sync_all_cmd | input | 1 | Full resync command pulse, also clears the counter |
| event_done | input | 1 | One pending event has been read out |
| cfg_max_pend | input | 4 | Cap on pending triggers (1..15, 0 acts as 1) |
| cfg_burst_len | input | 4 | Pulses per accepted trigger (1..15, 0 acts as 1) |
| cfg_delay | input | 4 | Extra delay in cycles (0..15) |
| cfg_auto_sync_dis | input | 1 | 1 disables the automatic idle resync |
| fe_trig_out | output | 1 | Trigger line to the front-end chips |
| fe_sync_out | output | 1 | Resync line to the front-end chips |
| pend_push | output | 1 | Push strobe for the pending-trigger FIFO |
| pend_num | output | 8 | Trigger number pushed with `pend_push` |
| pend_cnt | output | 4 | Triggers awaiting readout |
| trig_count | output | 8 | Next trigger number |

## Verification
Each result has a fixed latency, and every check samples in that cycle:
- `pend_push`, `pend_num`, `pend_cnt`, `trig_count` and the resync pulse from a command are due one cycle after the stimulus.
- The automatic resync is due two cycles after the `event_done` that empties the count.
- A burst occupies cycles D+1 through D+N after the trigger cycle.

The bench changes inputs a short time after each rising edge and then counts whole edges. The burst sweep records `fe_trig_out` over a 40-cycle window for every delay from 0 to 15 and several burst lengths, and it compares each cycle of that window with the window computed arithmetically in the bench.

// File: rtl/trig_sync_pkg.sv
package trig_sync_pkg;
  localparam int CFG_W      = 4;
  localparam int TNUM_W     = 8;
  localparam int DLY_STAGES = 16;
endpackage

// File: rtl/trig_burst_gen.sv
module trig_burst_gen #(
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic [CFG_W-1:0] len,
  output logic             busy,
  output logic             pulse
);
  logic [CFG_W-1:0] cnt_q, cnt_d;
  logic [CFG_W-1:0] len_eff;

  assign len_eff = (len == '0) ? CFG_W'(1) : len;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (start)         cnt_d = len_eff;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy  = (cnt_q != '0);
  assign pulse = busy;

  // R3: a running burst only counts down unless cleared or restarted
  a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/trig_delay_line.sv
module trig_delay_line #(
  parameter int STAGES = 16,
  parameter int SEL_W  = $clog2(STAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             dout
);
  logic [STAGES-1:0] sr_q, sr_d;
  logic [SEL_W-1:0]  tap;

  always_comb begin
    if (clr) sr_d = '0;
    else     sr_d = {sr_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign tap  = sel - 1'b1;
  assign dout = (sel == '0) ? din : sr_q[tap];
endmodule

// File: rtl/trig_pend_tracker.sv
module trig_pend_tracker #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                                cnt_d = '0;
    else if (inc && !dec && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    else if (dec && !inc && cnt_q != '0)      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R5: the count never underflows
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && dec && !inc) |=> (cnt_q == '0));
  // R5: the count never wraps past its top value
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && inc && !clr) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/trig_sync_ctrl.sv
module trig_sync_ctrl
  import trig_sync_pkg::*;
#(
  parameter int CW = CFG_W,
  parameter int NW = TNUM_W,
  parameter int DS = DLY_STAGES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_in,
  input  logic          sync_fe_cmd,
  input  logic          sync_all_cmd,
  input  logic          event_done,
  input  logic [CW-1:0] cfg_max_pend,
  input  logic [CW-1:0] cfg_burst_len,
  input  logic [CW-1:0] cfg_delay,
  input  logic          cfg_auto_sync_dis,
  output logic          fe_trig_out,
  output logic          fe_sync_out,
  output logic          pend_push,
  output logic [NW-1:0] pend_num,
  output logic [CW-1:0] pend_cnt,
  output logic [NW-1:0] trig_count
);
  localparam int SEL_W = $clog2(DS);

  logic          any_sync, accept, burst_busy, burst_pulse;
  logic [CW-1:0] max_eff;
  logic          idle, auto_fire;
  logic          idle_q, idle_d;
  logic          sync_q, sync_d;
  logic          push_q, push_d;
  logic [NW-1:0] num_q, num_d;
  logic [NW-1:0] tcnt_q, tcnt_d;

  assign any_sync = sync_fe_cmd | sync_all_cmd;
  assign max_eff  = (cfg_max_pend == '0) ? CW'(1) : cfg_max_pend;
  assign accept   = trig_in && !any_sync && !burst_busy && (pend_cnt < max_eff);

  trig_burst_gen #(.CFG_W(CW)) u_burst (
    .clk(clk), .rst_n(rst_n), .clr(any_sync), .start(accept),
    .len(cfg_burst_len), .busy(burst_busy), .pulse(burst_pulse)
  );

  trig_delay_line #(.STAGES(DS), .SEL_W(SEL_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .clr(any_sync), .din(burst_pulse),
    .sel(SEL_W'(cfg_delay)), .dout(fe_trig_out)
  );

  trig_pend_tracker #(.CNT_W(CW)) u_pend (
    .clk(clk), .rst_n(rst_n), .clr(any_sync), .inc(accept),
    .dec(event_done), .cnt(pend_cnt)
  );

  assign idle      = (pend_cnt == '0);
  assign auto_fire = idle && !idle_q && !cfg_auto_sync_dis;

  always_comb begin
    idle_d = any_sync ? 1'b1 : idle;
    sync_d = any_sync | auto_fire;
    push_d = accept;
    num_d  = accept ? tcnt_q : num_q;
    tcnt_d = tcnt_q;
    if (sync_all_cmd) tcnt_d = '0;
    else if (accept)  tcnt_d = tcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b1;
      sync_q <= 1'b0;
      push_q <= 1'b0;
      num_q  <= '0;
      tcnt_q <= '0;
    end else begin
      idle_q <= idle_d;
      sync_q <= sync_d;
      push_q <= push_d;
      num_q  <= num_d;
      tcnt_q <= tcnt_d;
    end
  end

  assign fe_sync_out = sync_q;
  assign pend_push   = push_q;
  assign pend_num    = num_q;
  assign trig_count  = tcnt_q;

  // R6: an accepted trigger is pushed next cycle with the old counter value
  a_r6_push_num: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (pend_push && pend_num == $past(trig_count)));
  // R2: a trigger during a burst is not pushed
  a_r2_refuse_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_in && burst_busy) |=> !pend_push);
  // R8: full resync clears the trigger counter
  a_r8_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sync_all_cmd |=> (trig_count == '0));
  // R9: an automatic resync is not repeated on the following cycle
  a_r9_auto_once: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_sync_out && !$past(any_sync)) |=> (!fe_sync_out || $past(any_sync)));
endmodule

// File: tb/tb_trig_sync_ctrl.sv
module tb_trig_sync_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       trig_in, sync_fe_cmd, sync_all_cmd, event_done;
  logic [3:0] cfg_max_pend, cfg_burst_len, cfg_delay;
  logic       cfg_auto_sync_dis;
  logic       fe_trig_out, fe_sync_out, pend_push;
  logic [7:0] pend_num, trig_count;
  logic [3:0] pend_cnt;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  trig_sync_ctrl dut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .sync_fe_cmd(sync_fe_cmd),
    .sync_all_cmd(sync_all_cmd), .event_done(event_done),
    .cfg_max_pend(cfg_max_pend), .cfg_burst_len(cfg_burst_len),
    .cfg_delay(cfg_delay), .cfg_auto_sync_dis(cfg_auto_sync_dis),
    .fe_trig_out(fe_trig_out), .fe_sync_out(fe_sync_out),
    .pend_push(pend_push), .pend_num(pend_num), .pend_cnt(pend_cnt),
    .trig_count(trig_count)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests = tests + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_trig();
    trig_in = 1'b1; tick(); trig_in = 1'b0;
  endtask

  task automatic pulse_done();
    event_done = 1'b1; tick(); event_done = 1'b0;
  endtask

  initial begin
    int bad;
    int seen;
    int expn;
    rst_n = 1'b0; trig_in = 0; sync_fe_cmd = 0; sync_all_cmd = 0; event_done = 0;
    cfg_max_pend = 4'd15; cfg_burst_len = 4'd1; cfg_delay = 4'd0; cfg_auto_sync_dis = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 trig", fe_trig_out, 0);
    chk("R1 sync", fe_sync_out, 0);
    chk("R1 push", pend_push, 0);
    chk("R1 pend", pend_cnt, 0);
    chk("R1 count", trig_count, 0);
    chk("R1 num", pend_num, 0);

    // R3/R4/R6 sweep: every delay, several burst lengths
    expn = 0;
    for (int d = 0; d < 16; d++) begin
      for (int li = 0; li < 5; li++) begin
        int n;
        n = (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 2 : (li == 3) ? 5 : 15;
        cfg_delay = 4'(d); cfg_burst_len = 4'(n);
        if (n == 0) n = 1;
        bad = 0; seen = 0;
        trig_in = 1'b1; tick(); trig_in = 1'b0;
        chk("R6 push", pend_push, 1);
        chk("R6 num", pend_num, expn % 256);
        for (int k = 1; k <= 40; k++) begin
          int e;
          if (k > 1) tick();
          e = (k >= d + 1 && k <= d + n) ? 1 : 0;
          if (fe_trig_out != e) bad = bad + 1;
          seen = seen + fe_trig_out;
        end
        chk("R4 window", bad, 0);
        chk("R3 pulses", seen, n);
        expn = expn + 1;
        pulse_done();
      end
    end
    chk("R6 count", trig_count, expn % 256);

    // R2 cap at 2 and burst busy
    cfg_delay = 0; cfg_burst_len = 1; cfg_max_pend = 4'd2; tick();
    chk("R5 idle", pend_cnt, 0);
    pulse_trig(); tick(); tick();
    pulse_trig(); tick(); tick();
    chk("R5 inc", pend_cnt, 2);
    pulse_trig();
    chk("R2 cap refuse", pend_push, 0);
    chk("R2 cap pend", pend_cnt, 2);
    tick();
    chk("R2 cap trig", fe_trig_out, 0);
    pulse_done(); pulse_done();
    cfg_max_pend = 4'd0; tick();
    pulse_trig(); tick(); tick();
    pulse_trig();
    chk("R2 zero cap acts as one", pend_cnt, 1);
    pulse_done();
    cfg_max_pend = 4'd15; cfg_burst_len = 4'd6; tick();
    pulse_trig(); tick(); tick();
    expn = trig_count;
    pulse_trig();
    chk("R2 busy refuse", pend_push, 0);
    chk("R2 busy count", trig_count, expn);
    repeat (8) tick();
    pulse_done();
    chk("R5 back to zero", pend_cnt, 0);

    // R5 underflow, simultaneous, saturation
    pulse_done();
    chk("R5 underflow", pend_cnt, 0);
    cfg_burst_len = 1;
    pulse_trig(); tick(); tick();
    trig_in = 1; event_done = 1; tick(); trig_in = 0; event_done = 0;
    chk("R5 both", pend_cnt, 1);
    tick(); tick();
    for (int i = 0; i < 16; i++) begin pulse_trig(); tick(); tick(); end
    chk("R5 saturate", pend_cnt, 15);

    // R7 front-end resync
    expn = trig_count;
    sync_fe_cmd = 1; trig_in = 1; tick(); sync_fe_cmd = 0; trig_in = 0;
    chk("R7 sync pulse", fe_sync_out, 1);
    chk("R7 pend clear", pend_cnt, 0);
    chk("R7 count kept", trig_count, expn);
    chk("R7 trig dropped", pend_push, 0);
    tick();
    chk("R10 single", fe_sync_out, 0);
    // R7 clears the delay line
    cfg_delay = 4'd8; tick();
    pulse_trig(); tick(); tick();
    sync_fe_cmd = 1; tick(); sync_fe_cmd = 0;
    seen = 0;
    for (int k = 0; k < 20; k++) begin seen = seen + fe_trig_out; tick(); end
    chk("R7 delay cleared", seen, 0);
    cfg_delay = 0;

    // R8 full resync
    pulse_trig(); tick(); tick();
    sync_all_cmd = 1; tick(); sync_all_cmd = 0;
    chk("R8 sync pulse", fe_sync_out, 1);
    chk("R8 count clear", trig_count, 0);
    chk("R8 pend clear", pend_cnt, 0);
    pulse_trig();
    chk("R8 num restart", pend_num, 0);
    tick(); tick();

    // R9 automatic resync
    cfg_auto_sync_dis = 0; tick();
    chk("R9 no sync on cmd clear", fe_sync_out, 0);
    pulse_done();
    chk("R9 not yet", fe_sync_out, 0);
    tick();
    chk("R9 auto pulse", fe_sync_out, 1);
    tick();
    chk("R10 auto single", fe_sync_out, 0);
    seen = 0;
    for (int k = 0; k < 6; k++) begin tick(); seen = seen + fe_sync_out; end
    chk("R9 once", seen, 0);
    cfg_auto_sync_dis = 1;
    pulse_trig(); tick(); tick();
    pulse_done();
    seen = 0;
    for (int k = 0; k < 4; k++) begin tick(); seen = seen + fe_sync_out; end
    chk("R9 disabled", seen, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule